// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking page tables held in memory. It starts from a context table base and a context number, which give the address of a root descriptor. From there it goes down through up to three directory levels, one word read per level, until it finds a leaf entry. A leaf can sit at level 1, 2 or 3, so pages are 16 MB, 256 KB or 4 KB. The walker then checks the leaf's access code against the requested access type and privilege. When needed, it sets the referenced and modified bits of the leaf and writes the entry back.

A translation request is taken with a ready/valid handshake. Only one walk runs at a time, and memory traffic uses a simple request/response port with one access outstanding. Each walk ends in a single-cycle response pulse. The pulse carries either a physical address, a permission set and a page size, or a fault code. A fault also updates a fault status register and a fault address register. The status register records overflow when a second fault arrives before software has acknowledged the first. Software acknowledges it by pulsing a clear input.

Top module: `ptw_walker`

## Requirements
- R1: The root descriptor is read from (ctx_table_base << 4) + (ctx_id << 2), truncated to 32 bits. A directory entry at level n-1 leads to the level-n entry at ((entry & ~3) << 4) plus an index of 4 × VA[31:24] for level 1, 4 × VA[23:18] for level 2 and 4 × VA[17:12] for level 3.
- R2: Bits [1:0] of every table word give its type: 0 invalid, 1 directory, 2 leaf, 3 reserved. A fault code is (level << 8) | (t << 2), with t = 1 for an invalid entry and t = 4 for a reserved entry. A leaf at the root (level 0) and a directory at level 3 are both reported as reserved.
- R3: A leaf has PPN in bits [31:8]. The physical address is (PPN << 12) plus the page offset: VA[23:0] for a level-1 leaf, VA[17:0] for level 2 and VA[11:0] for level 3. rsp_size is 2, 1 or 0 for 16 MB, 256 KB and 4 KB.
- R4: The leaf access code is bits [4:2]. The rights it grants, as read/write/execute, are: for a user access 0:R 1:RW 2:RX 3:RWX 4:X 5:R 6:none 7:none; for a supervisor access 0:R 1:RW 2:RX 3:RWX 4:X 5:RW 6:RX 7:RWX. A user access to code 6 or 7 faults with code 12. Otherwise, a read that lacks R, a write that lacks W, or a fetch that lacks X faults with code 8. An access flagged both write and fetch needs W and X.
- R5: rsp_perm is {X,W,R} of the rights for the access's privilege, with W removed when the leaf's modified bit (bit 6) is clear after the walk.
- R6: The leaf is written back when its referenced bit (bit 5) is clear, or when the access is a write and the modified bit is clear. The written word has bit 5 set, and also bit 6 set for a write. No write-back happens on a fault.
- R7: With nofault_mode set, access-check faults are suppressed for user accesses, which then complete normally. Supervisor accesses are not affected.
- R8: On a fault, the status register receives (A << 5) | code | 2, where A = {write, ifetch, super}, and far_q receives the request's virtual address.
- R9: If the status register is nonzero when a fault arrives, its old value is replaced by 1 before the new fields are ORed in.
- R10: A pulse on fsr_ack clears the status register to zero in the next cycle. A fault in the same cycle sees the cleared value.
- R11: req_ready is low from the acceptance cycle until the response. Each accepted request gets exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is privileged |
| ctx_table_base | input | 32 | Context table pointer (address >> 4) |
| ctx_id | input | CTX_W | Current context number |
| nofault_mode | input | 1 | Suppress user access-check faults |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Memory response (read data or write done) |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Walk finished (one-cycle pulse) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_paddr | output | 36 | Physical address |
| rsp_perm | output | 3 | Granted rights {X,W,R} |
| rsp_size | output | 2 | Page size code |
| rsp_fcode | output | 10 | Fault code, zero on success |
| fsr_ack | input | 1 | Acknowledge and clear status register |
| fsr_q | output | 10 | Fault status register |
| far_q | output | 32 | Fault address register |

## Verification
Latency is fixed against a memory that answers one cycle after it accepts a request. Each table read takes two cycles and the access check takes one. A write-back adds two cycles, and the response adds one more. A 4 KB walk with no write-back therefore answers ten cycles after acceptance, and a fault on the k-th read answers after 2k+1 cycles.

The bench counts cycles from the acceptance edge and samples outputs on the falling edge. It compares the count with these figures on every walk. The status and address registers are updated on the edge that ends the response pulse, so the bench reads them one falling edge after rsp_valid. The same sample confirms that the pulse lasted only one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int PPN_W    = 24;
    localparam int PG_SHIFT = 12;
    localparam int PA_W     = PPN_W + PG_SHIFT;
    localparam int LVL_W    = 2;
    localparam int ACC_W    = 3;
    localparam int CODE_W   = 10;
    localparam int FSR_W    = CODE_W;
    localparam int AIDX_W   = 3;

    localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

    localparam logic [2:0] FT_INVALID  = 3'd1;
    localparam logic [2:0] FT_RESERVED = 3'd4;
    localparam logic [3:0] AE_NONE     = 4'd0;
    localparam logic [3:0] AE_PROT     = 4'd8;
    localparam logic [3:0] AE_PRIV     = 4'd12;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_TABLE   = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2
    } pgsize_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_RWAIT, S_CHECK, S_WR, S_WWAIT, S_DONE, S_FAULT
    } wstate_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             cacheable;
        logic             modified;
        logic             referenced;
        logic [ACC_W-1:0] acc;
        etype_e           et;
    } pte_t;

    // rights as {exec, write, read}
    function automatic logic [2:0] acc_rights(input logic [ACC_W-1:0] acc, input logic user);
        case (acc)
            3'd0:    return 3'b001;
            3'd1:    return 3'b011;
            3'd2:    return 3'b101;
            3'd3:    return 3'b111;
            3'd4:    return 3'b100;
            3'd5:    return user ? 3'b001 : 3'b011;
            3'd6:    return user ? 3'b000 : 3'b101;
            default: return user ? 3'b000 : 3'b111;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] walk_fault(input logic [LVL_W-1:0] lvl,
                                                     input logic [2:0] ft);
        return {lvl, 3'b000, ft, 2'b00};
    endfunction

    // byte offset of the entry inside the table at level nxt
    function automatic logic [VA_W-1:0] level_offset(input logic [LVL_W-1:0] nxt,
                                                     input logic [VA_W-1:0] va);
        case (nxt)
            2'd1:    return {22'b0, va[31:24], 2'b00};
            2'd2:    return {24'b0, va[23:18], 2'b00};
            default: return {24'b0, va[17:12], 2'b00};
        endcase
    endfunction

endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  pte_t              pte,
    input  logic              is_write,
    input  logic              is_ifetch,
    input  logic              is_super,
    input  logic              nofault,
    output logic [3:0]        err,
    output logic [2:0]        perm,
    output logic [AIDX_W-1:0] acc_idx
);

    logic [2:0] have;
    logic [2:0] need;
    logic [3:0] raw_err;

    always_comb begin
        have = acc_rights(pte.acc, !is_super);
        need = {is_ifetch, is_write, !(is_write || is_ifetch)};
        if (!is_super && pte.acc >= 3'd6)
            raw_err = AE_PRIV;
        else if ((need & ~have) != 3'b000)
            raw_err = AE_PROT;
        else
            raw_err = AE_NONE;
        err     = (nofault && !is_super) ? AE_NONE : raw_err;
        perm    = pte.modified ? have : (have & 3'b101);
        acc_idx = {is_write, is_ifetch, is_super};
    end

endmodule

// File: rtl/ptw_fault_log.sv
module ptw_fault_log
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              log_en,
    input  logic [FSR_W-1:0]  log_val,
    input  logic [VA_W-1:0]   log_addr,
    input  logic              clr,
    output logic [FSR_W-1:0]  fsr_q,
    output logic [VA_W-1:0]   far_q
);

    logic [FSR_W-1:0] base;

    always_comb base = clr ? '0 : fsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
            far_q <= '0;
        end else if (log_en) begin
            fsr_q <= ((base != '0) ? FSR_W'(1) : '0) | log_val | FSR_W'(2);
            far_q <= log_addr;
        end else if (clr) begin
            fsr_q <= '0;
        end
    end

    a_r8_fault_recorded: assert property (@(posedge clk) disable iff (rst)
        log_en |=> (fsr_q[1] && far_q == $past(log_addr)));

    a_r9_overflow_marked: assert property (@(posedge clk) disable iff (rst)
        (log_en && !clr && fsr_q != '0) |=> fsr_q[0]);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !log_en) |=> (fsr_q == '0));

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic              req_super,
    input  logic [31:0]       ctx_table_base,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic              nofault_mode,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [35:0]       rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic [1:0]        rsp_size,
    output logic [9:0]        rsp_fcode,
    input  logic              fsr_ack,
    output logic [9:0]        fsr_q,
    output logic [31:0]       far_q
);

    wstate_e            st;
    logic [LVL_W-1:0]   lvl_q;
    logic [VA_W-1:0]    va_q;
    logic               wr_q, if_q, su_q;
    logic [31:0]        addr_q;
    pte_t               pte_q;
    logic [CODE_W-1:0]  code_q;

    pte_t               rd_pte;
    logic [31:0]        next_ptr;
    logic [31:0]        root_addr;
    logic [3:0]         chk_err;
    logic [2:0]         chk_perm;
    logic [AIDX_W-1:0]  acc_idx;
    logic               need_wb;
    logic [PA_W-1:0]    pg_base;
    logic [PA_W-1:0]    pg_off;
    logic [FSR_W-1:0]   log_val;

    always_comb begin
        rd_pte    = pte_t'(mem_rsp_rdata);
        next_ptr  = {mem_rsp_rdata[27:2], 6'b000000};
        root_addr = {ctx_table_base[27:0], 4'b0000} + (32'(ctx_id) << 2);
        need_wb   = !pte_q.referenced || (wr_q && !pte_q.modified);
    end

    ptw_perm_check u_perm (
        .pte       (pte_q),
        .is_write  (wr_q),
        .is_ifetch (if_q),
        .is_super  (su_q),
        .nofault   (nofault_mode),
        .err       (chk_err),
        .perm      (chk_perm),
        .acc_idx   (acc_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            lvl_q  <= '0;
            va_q   <= '0;
            wr_q   <= 1'b0;
            if_q   <= 1'b0;
            su_q   <= 1'b0;
            addr_q <= '0;
            pte_q  <= '0;
            code_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    if_q   <= req_ifetch;
                    su_q   <= req_super;
                    addr_q <= root_addr;
                    lvl_q  <= '0;
                    code_q <= '0;
                    st     <= S_RD;
                end
                S_RD: if (mem_req_ready) st <= S_RWAIT;
                S_RWAIT: if (mem_rsp_valid) begin
                    case (rd_pte.et)
                        ET_INVALID: begin
                            code_q <= walk_fault(lvl_q, FT_INVALID);
                            st     <= S_FAULT;
                        end
                        ET_TABLE: begin
                            if (lvl_q == LAST_LVL) begin
                                code_q <= walk_fault(lvl_q, FT_RESERVED);
                                st     <= S_FAULT;
                            end else begin
                                addr_q <= next_ptr + level_offset(lvl_q + 2'd1, va_q);
                                lvl_q  <= lvl_q + 2'd1;
                                st     <= S_RD;
                            end
                        end
                        ET_LEAF: begin
                            if (lvl_q == '0) begin
                                code_q <= walk_fault(lvl_q, FT_RESERVED);
                                st     <= S_FAULT;
                            end else begin
                                pte_q <= rd_pte;
                                st    <= S_CHECK;
                            end
                        end
                        default: begin
                            code_q <= walk_fault(lvl_q, FT_RESERVED);
                            st     <= S_FAULT;
                        end
                    endcase
                end
                S_CHECK: begin
                    if (chk_err != AE_NONE) begin
                        code_q <= CODE_W'(chk_err);
                        st     <= S_FAULT;
                    end else if (need_wb) begin
                        pte_q.referenced <= 1'b1;
                        if (wr_q) pte_q.modified <= 1'b1;
                        st <= S_WR;
                    end else begin
                        st <= S_DONE;
                    end
                end
                S_WR:    if (mem_req_ready) st <= S_WWAIT;
                S_WWAIT: if (mem_rsp_valid) st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (st == S_IDLE);
        mem_req_valid = (st == S_RD) || (st == S_WR);
        mem_req_write = (st == S_WR);
        mem_req_addr  = addr_q;
        mem_req_wdata = pte_q;
        rsp_valid     = (st == S_DONE) || (st == S_FAULT);
        rsp_fault     = (st == S_FAULT);
        rsp_fcode     = code_q;
        rsp_perm      = chk_perm;
        pg_base       = {pte_q.ppn, {PG_SHIFT{1'b0}}};
        case (lvl_q)
            2'd1: begin
                pg_off   = {12'b0, va_q[23:0]};
                rsp_size = PG_16M;
            end
            2'd2: begin
                pg_off   = {18'b0, va_q[17:0]};
                rsp_size = PG_256K;
            end
            default: begin
                pg_off   = {24'b0, va_q[11:0]};
                rsp_size = PG_4K;
            end
        endcase
        rsp_paddr = pg_base + pg_off;
        log_val   = code_q | {2'b00, acc_idx, 5'b00000};
    end

    ptw_fault_log u_log (
        .clk      (clk),
        .rst      (rst),
        .log_en   (st == S_FAULT),
        .log_val  (log_val),
        .log_addr (va_q),
        .clr      (fsr_ack),
        .fsr_q    (fsr_q),
        .far_q    (far_q)
    );

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r6_writeback_marks_ref: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[5] && mem_req_wdata[1:0] == 2'b10));

    a_r5_write_needs_modified: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault && rsp_perm[1]) |-> pte_q.modified);

    a_r2_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_fcode[4:2] != 3'b000));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_ifetch, req_super;
    logic [31:0] req_vaddr, ctx_table_base;
    logic [7:0]  ctx_id;
    logic        nofault_mode;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        rsp_valid, rsp_fault;
    logic [35:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [1:0]  rsp_size;
    logic [9:0]  rsp_fcode;
    logic        fsr_ack;
    logic [9:0]  fsr_q;
    logic [31:0] far_q;

    always #4 clk = ~clk;

    ptw_walker #(.CTX_W(8)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_ifetch(req_ifetch), .req_super(req_super),
        .ctx_table_base(ctx_table_base), .ctx_id(ctx_id), .nofault_mode(nofault_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm), .rsp_size(rsp_size), .rsp_fcode(rsp_fcode),
        .fsr_ack(fsr_ack), .fsr_q(fsr_q), .far_q(far_q)
    );

    // word memory, 16 KB
    logic [31:0] mem [0:4095];
    logic [31:0] rd_log [0:7];
    int          rd_cnt;

    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[mem_req_addr[13:2]];
            if (mem_req_write) mem[mem_req_addr[13:2]] <= mem_req_wdata;
            else if (rd_cnt < 8) begin
                rd_log[rd_cnt] <= mem_req_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        r_fault, r_busy_ok, r_single_ok;
    logic [35:0] r_pa;
    logic [2:0]  r_perm;
    logic [1:0]  r_size;
    logic [9:0]  r_code;
    int          r_cyc;

    // rights {X,W,R} per access code, code 0 in the low bits
    localparam logic [23:0] USR_RIGHTS = {3'b000, 3'b000, 3'b001, 3'b100, 3'b111, 3'b101, 3'b011, 3'b001};
    localparam logic [23:0] SUP_RIGHTS = {3'b111, 3'b101, 3'b011, 3'b100, 3'b111, 3'b101, 3'b011, 3'b001};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pte(input logic [23:0] ppn, input bit m, input bit r,
                                           input logic [2:0] acc);
        return {ppn, 1'b0, m, r, acc, 2'b10};
    endfunction

    function automatic logic [2:0] rights_of(input int acc, input bit s);
        return s ? SUP_RIGHTS[acc*3 +: 3] : USR_RIGHTS[acc*3 +: 3];
    endfunction

    function automatic int exp_err(input int acc, input bit w, input bit x, input bit s);
        logic [2:0] need;
        need = {x, w, !(w || x)};
        if (!s && acc >= 6) return 12;
        if ((need & ~rights_of(acc, s)) != 3'b000) return 8;
        return 0;
    endfunction

    task automatic walk(input logic [31:0] va, input bit w, input bit x, input bit s);
        @(negedge clk);
        rd_cnt     = 0;
        req_vaddr  = va;
        req_write  = w;
        req_ifetch = x;
        req_super  = s;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_cyc     = 1;
        r_busy_ok = !req_ready;
        while (!rsp_valid && r_cyc < 200) begin
            @(negedge clk);
            r_cyc++;
        end
        r_fault = rsp_fault;
        r_pa    = rsp_paddr;
        r_perm  = rsp_perm;
        r_size  = rsp_size;
        r_code  = rsp_fcode;
        @(negedge clk);
        r_single_ok = !rsp_valid;
    endtask

    task automatic ack_fsr();
        @(negedge clk);
        fsr_ack = 1'b1;
        @(negedge clk);
        fsr_ack = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    function automatic logic [31:0] va4k(input logic [5:0] i3, input logic [11:0] off);
        return {8'h10, 6'd5, i3, off};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] va;
        logic [31:0] pte;
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_ifetch = 0; req_super = 0; req_vaddr = '0;
        ctx_table_base = '0; ctx_id = '0; nofault_mode = 0; fsr_ack = 0;
        mem_req_ready = 1'b1;
        rd_cnt = 0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // root descriptors: ctx0 -> L1 @0x400, ctx1 invalid, ctx2 leaf, ctx3 reserved
        mem[0] = 32'h41; mem[1] = 32'h0; mem[2] = 32'h2; mem[3] = 32'h3;
        mem[(32'h400 + 32'h10*4) >> 2] = 32'h81;                 // -> L2 @0x800
        mem[(32'h400 + 32'h20*4) >> 2] = mk_pte(24'h000123, 1, 1, 3'd3);
        mem[(32'h400 + 32'h30*4) >> 2] = 32'h0;
        mem[(32'h400 + 32'h31*4) >> 2] = 32'h3;
        mem[(32'h800 + 5*4) >> 2] = 32'hC1;                       // -> L3 @0xC00
        mem[(32'h800 + 7*4) >> 2] = mk_pte(24'h000ABC, 1, 1, 3'd3);
        mem[(32'h800 + 8*4) >> 2] = 32'h0;
        mem[(32'hC00 + 1*4) >> 2] = mk_pte(24'h000321, 1, 1, 3'd3);
        mem[(32'hC00 + 9*4) >> 2] = 32'hC1;
        mem[(32'hC00 + 10*4) >> 2] = 32'h0;
        mem[32'h100C >> 2] = 32'h41;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset req_ready", req_ready, 1);
        chk("R11 reset rsp_valid", rsp_valid, 0);
        chk("R11 reset mem_req_valid", mem_req_valid, 0);
        chk("R8 reset fsr", fsr_q, 0);
        chk("R8 reset far", far_q, 0);

        // R1: address sequence for a 4 KB walk
        va = va4k(6'd1, 12'h0AB);
        walk(va, 0, 0, 1);
        chk("R1 read count", rd_cnt, 4);
        chk("R1 root addr", rd_log[0], 32'h0);
        chk("R1 L1 addr", rd_log[1], 32'h440);
        chk("R1 L2 addr", rd_log[2], 32'h814);
        chk("R1 L3 addr", rd_log[3], 32'hC04);
        chk("R3 4K paddr", r_pa, (36'h321 << 12) + 36'h0AB);
        chk("R11 busy after accept", r_busy_ok, 1);
        chk("R11 single pulse", r_single_ok, 1);

        // R1: nonzero table base and context
        ctx_table_base = 32'h100; ctx_id = 8'd3;
        walk(va, 0, 0, 1);
        chk("R1 root addr with base", rd_log[0], 32'h100C);
        chk("R1 walk via base ok", r_fault, 0);
        ctx_table_base = '0; ctx_id = '0;

        // R4 R5 R8 R11: access code x access index sweep on a 4 KB leaf
        for (int acc = 0; acc < 8; acc++) begin
            for (int ai = 0; ai < 8; ai++) begin
                bit w, x, s;
                int e;
                w = ai[2]; x = ai[1]; s = ai[0];
                mem[(32'hC00 + 2*4) >> 2] = mk_pte(24'h000F00 + 24'(acc), 1, 1, 3'(acc));
                ack_fsr();
                va = va4k(6'd2, 12'h345);
                walk(va, w, x, s);
                e = exp_err(acc, w, x, s);
                chk("R11 latency 4K", r_cyc, 10);
                if (e != 0) begin
                    chk("R4 fault flag", r_fault, 1);
                    chk("R4 fault code", r_code, 10'(e));
                    chk("R8 fsr contents", fsr_q, 10'((ai << 5) | e | 2));
                    chk("R8 far contents", far_q, va);
                end else begin
                    chk("R4 no fault", r_fault, 0);
                    chk("R3 4K paddr sweep", r_pa, ((36'h000F00 + 36'(acc)) << 12) + 36'h345);
                    chk("R5 perm", r_perm, rights_of(acc, s));
                    chk("R3 4K size", r_size, 2'd0);
                end
            end
        end

        // R3: 16 MB and 256 KB leaves
        va = 32'h20ABCDEF;
        walk(va, 0, 0, 1);
        chk("R3 16M no fault", r_fault, 0);
        chk("R3 16M paddr", r_pa, (36'h123 << 12) + 36'hABCDEF);
        chk("R3 16M size", r_size, 2'd2);
        chk("R11 latency 16M", r_cyc, 6);
        va = {8'h10, 6'd7, 18'h2B7C9};
        walk(va, 0, 0, 1);
        chk("R3 256K paddr", r_pa, (36'hABC << 12) + 36'h2B7C9);
        chk("R3 256K size", r_size, 2'd1);
        chk("R11 latency 256K", r_cyc, 8);

        // R2: walk faults by level and entry type
        ack_fsr();
        ctx_id = 8'd1; walk(32'h0, 0, 0, 1);
        chk("R2 root invalid", r_code, 10'h004); chk("R11 latency root fault", r_cyc, 3);
        ctx_id = 8'd2; walk(32'h0, 0, 0, 1);
        chk("R2 root leaf", r_code, 10'h010);
        ctx_id = 8'd3; walk(32'h0, 0, 0, 1);
        chk("R2 root reserved", r_code, 10'h010);
        ctx_id = 8'd0;
        walk(32'h30000000, 0, 0, 1);
        chk("R2 L1 invalid", r_code, 10'h104); chk("R11 latency L1 fault", r_cyc, 5);
        walk(32'h31000000, 0, 0, 1);
        chk("R2 L1 reserved", r_code, 10'h110);
        walk({8'h10, 6'd8, 18'h0}, 0, 0, 1);
        chk("R2 L2 invalid", r_code, 10'h204); chk("R11 latency L2 fault", r_cyc, 7);
        walk(va4k(6'd10, 12'h0), 0, 0, 1);
        chk("R2 L3 invalid", r_code, 10'h304); chk("R11 latency L3 fault", r_cyc, 9);
        walk(va4k(6'd9, 12'h0), 0, 0, 1);
        chk("R2 L3 directory", r_code, 10'h310);
        chk("R2 fault flag", r_fault, 1);

        // R6 R5: referenced/modified write-back
        pte = mk_pte(24'h000077, 0, 0, 3'd3);
        mem[(32'hC00 + 12*4) >> 2] = pte;
        walk(va4k(6'd12, 12'h0), 0, 0, 1);
        chk("R6 wb on read latency", r_cyc, 12);
        chk("R6 ref set", mem[(32'hC00 + 12*4) >> 2], pte | 32'h20);
        chk("R5 write withheld", r_perm, 3'b101);
        walk(va4k(6'd12, 12'h0), 1, 0, 1);
        chk("R6 wb on write latency", r_cyc, 12);
        chk("R6 mod set", mem[(32'hC00 + 12*4) >> 2], pte | 32'h60);
        chk("R5 write granted", r_perm, 3'b111);
        walk(va4k(6'd12, 12'h0), 1, 0, 1);
        chk("R6 no wb latency", r_cyc, 10);
        pte = mk_pte(24'h000066, 0, 1, 3'd0);
        mem[(32'hC00 + 15*4) >> 2] = pte;
        walk(va4k(6'd15, 12'h0), 1, 0, 1);
        chk("R6 no wb on fault", mem[(32'hC00 + 15*4) >> 2], pte);

        // R7: no-fault mode
        nofault_mode = 1'b1;
        pte = mk_pte(24'h000055, 0, 1, 3'd0);
        mem[(32'hC00 + 13*4) >> 2] = pte;
        walk(va4k(6'd13, 12'h0), 1, 0, 0);
        chk("R7 user write suppressed", r_fault, 0);
        chk("R7 user perm", r_perm, 3'b001);
        chk("R7 wb latency", r_cyc, 12);
        chk("R7 mod set", mem[(32'hC00 + 13*4) >> 2], pte | 32'h40);
        walk(va4k(6'd13, 12'h0), 1, 0, 1);
        chk("R7 supervisor still faults", r_fault, 1);
        chk("R7 supervisor code", r_code, 10'd8);
        mem[(32'hC00 + 14*4) >> 2] = mk_pte(24'h000044, 1, 1, 3'd6);
        walk(va4k(6'd14, 12'h0), 0, 0, 0);
        chk("R7 user priv suppressed", r_fault, 0);
        chk("R7 user priv perm", r_perm, 3'b000);
        nofault_mode = 1'b0;

        // R9: overflow, R10: acknowledge
        ack_fsr();
        walk(32'h30000000, 0, 0, 0);
        chk("R8 first fault fsr", fsr_q, 10'h106);
        va = {8'h10, 6'd8, 18'h1234};
        walk(va, 1, 0, 1);
        chk("R9 overflow fsr", fsr_q, 10'h2A7);
        chk("R8 far second", far_q, va);
        ack_fsr();
        chk("R10 cleared", fsr_q, 10'h000);
        chk("R10 far kept", far_q, va);

        summary();
        $finish;
    end

endmodule